// File: doc/BRIEF.md
# Four-Plane Write/Read Data Path

This block sits between a processor byte port and four 8-bit bit planes of video memory. Every processor read loads a 32-bit latch with the byte from all four planes at once. The byte returned to the processor is either one chosen plane or a colour-compare byte, which marks the pixel positions whose four plane bits equal a reference colour.

On a processor write the block builds one output byte per plane. Write mode 0 rotates the processor byte, may replace it per plane with a set/reset fill, combines it with the latch through a logic function, and merges the result with the latch under a bit mask. Write mode 1 copies the latch back unchanged. Write mode 2 fills each plane from one processor data bit, then applies the function and the bit mask. A per-plane enable mask decides which planes the memory actually stores.

The memory is modelled as ports. The current planes arrive on one 32-bit bus, with plane p in bits 8p+7..8p. Address decode and the memory arrays are outside the block. All control fields arrive as plain inputs.

Top module: `plane_rw_unit`

## Requirements
- R1: After reset `rdValid`, `cpuRdData`, `memWrEn` and the internal latch are all zero. A write in mode 1 straight after reset therefore produces all-zero plane data.
- R2: A `cpuRd` pulse in cycle N loads all four latch bytes from `memRdData`, whatever the read mode. In cycle N+1 `rdValid` is 1 and `cpuRdData` holds the result. `rdValid` is 0 in every other cycle.
- R3: With `readMode`=0, `cpuRdData` is the byte of plane `readSel`, taken from bits 8*`readSel`+7..8*`readSel` of `memRdData`.
- R4: With `readMode`=1, bit b of `cpuRdData` is 1 when, for every plane p with `cmpCare`[p]=1, bit b of plane p equals `cmpColor`[p]. A plane with `cmpCare`[p]=0 never causes a mismatch.
- R5: In write mode 0 (`writeMode`=0), the processor byte is rotated right by `rotCount` before it is used, so result bit b equals data bit (b+`rotCount`) mod 8.
- R6: In write mode 0, a plane p with `setRstEn`[p]=1 uses all ones (if `setRst`[p]=1) or all zeros in place of the rotated byte.
- R7: In write modes 0 and 2, `aluFn` combines the source with that plane's latch byte: 0 passes the source, 1 gives AND, 2 gives OR, 3 gives XOR.
- R8: In write modes 0 and 2, every plane's output bit b is the function result where `bitMask`[b]=1 and the latch bit where `bitMask`[b]=0.
- R9: A `cpuWr` pulse in cycle N with `writeMode` 0, 1 or 2 drives `memWrData` and `memWrEn`=`mapMask` in cycle N+1. `memWrEn` is zero in every cycle that does not follow a write.
- R10: In write mode 1, every plane's output byte equals its latch byte, whatever `cpuWrData`, `bitMask`, `aluFn` and set/reset hold.
- R11: In write mode 2, plane p's source is all ones when `cpuWrData`[p]=1 and all zeros otherwise.
- R12: A write with `writeMode`=3 enables no plane: `memWrEn` stays zero.
- R13: When `cpuRd` and `cpuWr` are both high in one cycle, the write uses the latch contents from before that read, the read returns the new planes, and the next write sees the new latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuRd | input | 1 | One-cycle processor read strobe |
| cpuWr | input | 1 | One-cycle processor write strobe |
| cpuWrData | input | 8 | Processor write byte |
| cpuRdData | output | 8 | Read result, valid with rdValid |
| rdValid | output | 1 | Read result present (cycle after cpuRd) |
| readMode | input | 1 | 0 = plane byte, 1 = colour compare |
| readSel | input | 2 | Plane returned in read mode 0 |
| writeMode | input | 2 | Write mode 0, 1, 2 (3 = no write) |
| rotCount | input | 3 | Right-rotate count for write mode 0 |
| aluFn | input | 2 | 0 pass, 1 AND, 2 OR, 3 XOR |
| setRst | input | 4 | Per-plane fill value for set/reset |
| setRstEn | input | 4 | Per-plane set/reset enable |
| bitMask | input | 8 | 1 = take result bit, 0 = keep latch bit |
| mapMask | input | 4 | Per-plane write enable |
| cmpColor | input | 4 | Reference colour for compare reads |
| cmpCare | input | 4 | Planes that take part in compare |
| memRdData | input | 32 | Current bytes of all four planes |
| memWrData | output | 32 | Bytes to store, plane p in bits 8p+7..8p |
| memWrEn | output | 4 | Per-plane store enable, one cycle |

## Verification
A latch load by a read and a latch use by a write can fall in the same cycle. The bench provokes this by raising `cpuRd` and `cpuWr` together, with a plane image different from the one last latched. It judges the outcome from three results: the write data must show the old latch, the read byte must come from the new image, and a following mode 1 write must return the new image. The colour-compare path is also checked against a latch image that is read back through a write, which shows that a compare read still loads the latch.

// File: rtl/vpl_pkg.sv
package vpl_pkg;

  localparam int PLANE_COUNT = 4;
  localparam int PLANE_BITS  = 8;

  typedef enum logic [1:0] {
    WM_DIRECT = 2'd0,
    WM_COPY   = 2'd1,
    WM_FILL   = 2'd2,
    WM_NONE   = 2'd3
  } wrModeE;

  typedef enum logic [1:0] {
    FN_PASS = 2'd0,
    FN_AND  = 2'd1,
    FN_OR   = 2'd2,
    FN_XOR  = 2'd3
  } aluFnE;

  typedef struct packed {
    logic   latchLoad;
    logic   rdCapture;
    logic   rdUseCmp;
    logic   wrCapture;
    logic   wrPlanesOn;
    wrModeE wrMode;
  } ctrlStrobeT;

endpackage

// File: rtl/vpl_lane.sv
module vpl_lane
  import vpl_pkg::*;
#(
  parameter int BYTEW = PLANE_BITS
) (
  input  wrModeE           mode,
  input  aluFnE            fn,
  input  logic [BYTEW-1:0] latchByte,
  input  logic [BYTEW-1:0] rotByte,
  input  logic             setRstBit,
  input  logic             setRstEnBit,
  input  logic             fillBit,
  input  logic [BYTEW-1:0] bitMask,
  output logic [BYTEW-1:0] wrByte
);

  logic [BYTEW-1:0] srcByte;
  logic [BYTEW-1:0] aluByte;
  logic [BYTEW-1:0] mergedByte;

  // source selection: rotated byte, set/reset fill or data-bit fill
  always_comb begin
    case (mode)
      WM_DIRECT: srcByte = setRstEnBit ? {BYTEW{setRstBit}} : rotByte;
      WM_FILL:   srcByte = {BYTEW{fillBit}};
      default:   srcByte = rotByte;
    endcase
  end

  // logic function against the latched plane byte
  always_comb begin
    case (fn)
      FN_AND:  aluByte = srcByte & latchByte;
      FN_OR:   aluByte = srcByte | latchByte;
      FN_XOR:  aluByte = srcByte ^ latchByte;
      default: aluByte = srcByte;
    endcase
  end

  assign mergedByte = (aluByte & bitMask) | (latchByte & ~bitMask);
  assign wrByte     = (mode == WM_COPY) ? latchByte : mergedByte;

endmodule

// File: rtl/vpl_ctrl.sv
module vpl_ctrl
  import vpl_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuRd,
  input  logic       cpuWr,
  input  logic       readMode,
  input  logic [1:0] writeMode,
  output ctrlStrobeT strobe,
  output logic       rdValid
);

  wrModeE modeNow;

  assign modeNow = wrModeE'(writeMode);

  always_comb begin
    strobe            = '0;
    strobe.latchLoad  = cpuRd;
    strobe.rdCapture  = cpuRd;
    strobe.rdUseCmp   = readMode;
    strobe.wrCapture  = cpuWr;
    strobe.wrPlanesOn = cpuWr && (modeNow != WM_NONE);
    strobe.wrMode     = modeNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdValid <= 1'b0;
    else       rdValid <= cpuRd;
  end

endmodule

// File: rtl/vpl_dpath.sv
module vpl_dpath
  import vpl_pkg::*;
#(
  parameter int NPLANES = PLANE_COUNT,
  parameter int BYTEW   = PLANE_BITS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrlStrobeT                 strobe,
  input  logic [BYTEW-1:0]           cpuWrData,
  input  logic [$clog2(NPLANES)-1:0] readSel,
  input  logic [$clog2(BYTEW)-1:0]   rotCount,
  input  logic [1:0]                 aluFn,
  input  logic [NPLANES-1:0]         setRst,
  input  logic [NPLANES-1:0]         setRstEn,
  input  logic [BYTEW-1:0]           bitMask,
  input  logic [NPLANES-1:0]         mapMask,
  input  logic [NPLANES-1:0]         cmpColor,
  input  logic [NPLANES-1:0]         cmpCare,
  input  logic [NPLANES*BYTEW-1:0]   memRdData,
  output logic [BYTEW-1:0]           cpuRdData,
  output logic [NPLANES*BYTEW-1:0]   memWrData,
  output logic [NPLANES-1:0]         memWrEn
);

  localparam int BUSW = NPLANES * BYTEW;

  logic [BUSW-1:0]    latchQ;
  logic [BUSW-1:0]    wrNext;
  logic [2*BYTEW-1:0] dblByte;
  logic [BYTEW-1:0]   rotByte;
  logic [BYTEW-1:0]   selByte;
  logic [BYTEW-1:0]   cmpByte;
  aluFnE              fnNow;

  assign fnNow   = aluFnE'(aluFn);
  assign dblByte = {cpuWrData, cpuWrData};
  assign rotByte = dblByte[rotCount +: BYTEW];
  assign selByte = memRdData[readSel*BYTEW +: BYTEW];

  // colour compare: one column of plane bits per pixel position
  for (genvar b = 0; b < BYTEW; b++) begin : gCmp
    logic [NPLANES-1:0] column;
    for (genvar p = 0; p < NPLANES; p++) begin : gCol
      assign column[p] = memRdData[p*BYTEW + b];
    end
    assign cmpByte[b] = &(~cmpCare | ~(column ^ cmpColor));
  end

  // one write lane per plane
  for (genvar p = 0; p < NPLANES; p++) begin : gLane
    vpl_lane #(.BYTEW(BYTEW)) uLane (
      .mode        (strobe.wrMode),
      .fn          (fnNow),
      .latchByte   (latchQ[p*BYTEW +: BYTEW]),
      .rotByte     (rotByte),
      .setRstBit   (setRst[p]),
      .setRstEnBit (setRstEn[p]),
      .fillBit     (cpuWrData[p]),
      .bitMask     (bitMask),
      .wrByte      (wrNext[p*BYTEW +: BYTEW])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchQ    <= '0;
      cpuRdData <= '0;
      memWrData <= '0;
      memWrEn   <= '0;
    end else begin
      if (strobe.latchLoad) latchQ <= memRdData;
      if (strobe.rdCapture) cpuRdData <= strobe.rdUseCmp ? cmpByte : selByte;
      if (strobe.wrCapture) memWrData <= wrNext;
      memWrEn <= strobe.wrPlanesOn ? mapMask : '0;
    end
  end

endmodule

// File: rtl/plane_rw_unit.sv
module plane_rw_unit
  import vpl_pkg::*;
#(
  parameter int NPLANES = PLANE_COUNT,
  parameter int BYTEW   = PLANE_BITS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cpuRd,
  input  logic                       cpuWr,
  input  logic [BYTEW-1:0]           cpuWrData,
  output logic [BYTEW-1:0]           cpuRdData,
  output logic                       rdValid,
  input  logic                       readMode,
  input  logic [$clog2(NPLANES)-1:0] readSel,
  input  logic [1:0]                 writeMode,
  input  logic [$clog2(BYTEW)-1:0]   rotCount,
  input  logic [1:0]                 aluFn,
  input  logic [NPLANES-1:0]         setRst,
  input  logic [NPLANES-1:0]         setRstEn,
  input  logic [BYTEW-1:0]           bitMask,
  input  logic [NPLANES-1:0]         mapMask,
  input  logic [NPLANES-1:0]         cmpColor,
  input  logic [NPLANES-1:0]         cmpCare,
  input  logic [NPLANES*BYTEW-1:0]   memRdData,
  output logic [NPLANES*BYTEW-1:0]   memWrData,
  output logic [NPLANES-1:0]         memWrEn
);

  ctrlStrobeT strobe;

  vpl_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .readMode  (readMode),
    .writeMode (writeMode),
    .strobe    (strobe),
    .rdValid   (rdValid)
  );

  vpl_dpath #(.NPLANES(NPLANES), .BYTEW(BYTEW)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .cpuWrData (cpuWrData),
    .readSel   (readSel),
    .rotCount  (rotCount),
    .aluFn     (aluFn),
    .setRst    (setRst),
    .setRstEn  (setRstEn),
    .bitMask   (bitMask),
    .mapMask   (mapMask),
    .cmpColor  (cmpColor),
    .cmpCare   (cmpCare),
    .memRdData (memRdData),
    .cpuRdData (cpuRdData),
    .memWrData (memWrData),
    .memWrEn   (memWrEn)
  );

endmodule

// File: rtl/plane_rw_unit_chk.sv
module plane_rw_unit_chk #(
  parameter int NPLANES = 4,
  parameter int BYTEW   = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       cpuRd,
  input logic                       cpuWr,
  input logic                       readMode,
  input logic [$clog2(NPLANES)-1:0] readSel,
  input logic [1:0]                 writeMode,
  input logic [BYTEW-1:0]           bitMask,
  input logic [NPLANES-1:0]         mapMask,
  input logic [NPLANES*BYTEW-1:0]   memRdData,
  input logic [BYTEW-1:0]           cpuRdData,
  input logic                       rdValid,
  input logic [NPLANES*BYTEW-1:0]   memWrData,
  input logic [NPLANES-1:0]         memWrEn
);

  logic [NPLANES*BYTEW-1:0] shadowLatch;
  logic [NPLANES*BYTEW-1:0] keepBits;
  logic [BYTEW-1:0]         pickedPlane;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      shadowLatch <= '0;
    else if (cpuRd) shadowLatch <= memRdData;
  end

  assign keepBits    = {NPLANES{~bitMask}};
  assign pickedPlane = memRdData[readSel*BYTEW +: BYTEW];

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    cpuRd |=> rdValid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |=> !rdValid);
  a_r3_plane_pick: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && !readMode) |=> (cpuRdData == $past(pickedPlane)));
  a_r9_enables: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && writeMode != 2'd3) |=> (memWrEn == $past(mapMask)));
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !cpuWr |=> (memWrEn == '0));
  a_r12_mode3_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && writeMode == 2'd3) |=> (memWrEn == '0));
  a_r10_copy_latch: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && writeMode == 2'd1) |=> (memWrData == $past(shadowLatch)));
  a_r8_masked_kept: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && writeMode != 2'd1) |=>
      (((memWrData ^ $past(shadowLatch)) & $past(keepBits)) == '0));

endmodule

bind plane_rw_unit plane_rw_unit_chk #(.NPLANES(NPLANES), .BYTEW(BYTEW)) uChk (.*);

// File: tb/sim_plane_rw_unit.sv
module sim_plane_rw_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuRd = 1'b0, cpuWr = 1'b0;
  logic [7:0]  cpuWrData = '0;
  logic [7:0]  cpuRdData;
  logic        rdValid;
  logic        readMode = 1'b0;
  logic [1:0]  readSel = '0;
  logic [1:0]  writeMode = '0;
  logic [2:0]  rotCount = '0;
  logic [1:0]  aluFn = '0;
  logic [3:0]  setRst = '0, setRstEn = '0;
  logic [7:0]  bitMask = 8'hFF;
  logic [3:0]  mapMask = 4'hF;
  logic [3:0]  cmpColor = '0, cmpCare = '0;
  logic [31:0] memRdData = '0;
  logic [31:0] memWrData;
  logic [3:0]  memWrEn;

  plane_rw_unit u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    bit          isWr;
    logic [31:0] val;
    logic [3:0]  en;
    bit          chkData;
    string       tag;
  } itemT;

  itemT        sbQ[$];
  int          cyc = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;
  logic [31:0] mLatch = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // model of the plane writes, built from the requirements
  function automatic logic [31:0] modelWrite(input logic [7:0] d, input logic [31:0] lat);
    logic [31:0] res;
    for (int p = 0; p < 4; p++) begin
      logic [7:0] l, s, f;
      l = lat[p*8 +: 8];
      for (int b = 0; b < 8; b++) s[b] = d[(b + int'(rotCount)) % 8];
      if (writeMode == 2'd0 && setRstEn[p]) s = {8{setRst[p]}};
      if (writeMode == 2'd2) s = {8{d[p]}};
      case (aluFn)
        2'd1: f = s & l;
        2'd2: f = s | l;
        2'd3: f = s ^ l;
        default: f = s;
      endcase
      res[p*8 +: 8] = (writeMode == 2'd1) ? l : ((f & bitMask) | (l & ~bitMask));
    end
    return res;
  endfunction

  function automatic logic [7:0] modelRead(input logic [31:0] m);
    logic [7:0] r;
    if (!readMode) return m[int'(readSel)*8 +: 8];
    for (int b = 0; b < 8; b++) begin
      r[b] = 1'b1;
      for (int p = 0; p < 4; p++)
        if (cmpCare[p] && m[p*8 + b] != cmpColor[p]) r[b] = 1'b0;
    end
    return r;
  endfunction

  // driver: one operation, expectations pushed to the scoreboard
  task automatic op(input bit rd, input bit wr, input logic [7:0] d, input logic [31:0] m, input string tag);
    itemT it;
    @(negedge clk);
    cpuRd = rd; cpuWr = wr; cpuWrData = d; memRdData = m;
    if (wr) begin
      it.due = cyc + 1; it.isWr = 1'b1;
      it.val = modelWrite(d, mLatch);
      it.en = (writeMode == 2'd3) ? 4'h0 : mapMask;
      it.chkData = (writeMode != 2'd3);
      it.tag = tag;
      sbQ.push_back(it);
    end
    if (rd) begin
      it.due = cyc + 1; it.isWr = 1'b0;
      it.val = {24'h0, modelRead(m)};
      it.en = '0; it.chkData = 1'b1; it.tag = tag;
      sbQ.push_back(it);
      mLatch = m;
    end
    @(negedge clk);
    cpuRd = 1'b0; cpuWr = 1'b0;
  endtask

  // monitor: pops due items and compares, flags unexpected outputs
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        bit sawWr, sawRd;
        sawWr = 1'b0; sawRd = 1'b0;
        while (sbQ.size() > 0 && sbQ[0].due == cyc) begin
          itemT it;
          it = sbQ.pop_front();
          if (it.isWr) begin
            sawWr = 1'b1;
            check(memWrEn == it.en, {it.tag, " enables"}, {28'h0, memWrEn}, {28'h0, it.en});
            if (it.chkData)
              check(memWrData == it.val, {it.tag, " write data"}, memWrData, it.val);
          end else begin
            sawRd = 1'b1;
            check(rdValid && cpuRdData == it.val[7:0], {it.tag, " read data"},
                  {23'h0, rdValid, cpuRdData}, {23'h0, 1'b1, it.val[7:0]});
          end
        end
        if (!sawWr && memWrEn != 4'h0)
          check(1'b0, "R9 unexpected write enable", {28'h0, memWrEn}, 32'h0);
        if (!sawRd && rdValid)
          check(1'b0, "R2 unexpected read valid", 32'h1, 32'h0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 32'h0, 32'h1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rdValid == 1'b0, "R1 rdValid after reset", {31'h0, rdValid}, 32'h0);
    check(cpuRdData == 8'h0, "R1 cpuRdData after reset", {24'h0, cpuRdData}, 32'h0);
    check(memWrEn == 4'h0, "R1 memWrEn after reset", {28'h0, memWrEn}, 32'h0);
    rstN = 1'b1;

    // R1: latch starts at zero
    writeMode = 2'd1;
    op(0, 1, 8'h5A, 32'h0, "R1 latch cleared");

    // R3: each plane chosen in turn
    readMode = 1'b0;
    for (int s = 0; s < 4; s++) begin
      readSel = 2'(s);
      op(1, 0, 8'h00, 32'hD49C_35A7, "R3 plane select");
    end

    // R4: colour compare, all planes cared and partial care
    readMode = 1'b1; cmpColor = 4'b1010; cmpCare = 4'hF;
    op(1, 0, 8'h00, 32'hF00F_F00F, "R4 compare full care");
    cmpCare = 4'b0011;
    op(1, 0, 8'h00, 32'h1234_A5C3, "R4 compare partial care");

    // R2: the compare read still loaded the latch
    writeMode = 2'd1;
    op(0, 1, 8'hFF, 32'h0, "R2 latch after compare read");

    // R5: rotation
    writeMode = 2'd0; aluFn = 2'd0; setRstEn = 4'h0; bitMask = 8'hFF;
    rotCount = 3'd0; op(0, 1, 8'hB1, 32'h0, "R5 rotate 0");
    rotCount = 3'd3; op(0, 1, 8'hB1, 32'h0, "R5 rotate 3");
    rotCount = 3'd7; op(0, 1, 8'h96, 32'h0, "R5 rotate 7");
    rotCount = 3'd0;

    // R6: set/reset substitution on planes 0 and 2
    setRstEn = 4'b0101; setRst = 4'b0100;
    op(0, 1, 8'h3C, 32'h0, "R6 set/reset");
    setRstEn = 4'h0;

    // R7: functions against a known latch
    readMode = 1'b0; readSel = 2'd0;
    op(1, 0, 8'h00, 32'hF0CC_AA0F, "R7 latch load");
    aluFn = 2'd1; op(0, 1, 8'h3C, 32'h0, "R7 AND");
    aluFn = 2'd2; op(0, 1, 8'h3C, 32'h0, "R7 OR");
    aluFn = 2'd3; op(0, 1, 8'h3C, 32'h0, "R7 XOR");
    aluFn = 2'd0;

    // R8: bit mask keeps latch bits
    bitMask = 8'h0F; op(0, 1, 8'hA5, 32'h0, "R8 mask low nibble");
    bitMask = 8'h00; op(0, 1, 8'hFF, 32'h0, "R8 mask none");
    bitMask = 8'hFF;

    // R9: per-plane enables
    mapMask = 4'b1010; op(0, 1, 8'h77, 32'h0, "R9 map mask 1010");
    mapMask = 4'b0000; op(0, 1, 8'h77, 32'h0, "R9 map mask 0000");
    mapMask = 4'hF;

    // R10: copy mode ignores data, mask, function and set/reset
    writeMode = 2'd1; bitMask = 8'h00; aluFn = 2'd3; setRstEn = 4'hF;
    op(0, 1, 8'hFF, 32'h0, "R10 copy latch");
    bitMask = 8'hFF; aluFn = 2'd0; setRstEn = 4'h0;

    // R11: data-bit fill, with function and mask applied
    writeMode = 2'd2; aluFn = 2'd3; bitMask = 8'hF0;
    op(0, 1, 8'b0000_0110, 32'h0, "R11 fill xor masked");
    aluFn = 2'd0; bitMask = 8'hFF;
    op(0, 1, 8'b1111_1001, 32'h0, "R11 fill pass");

    // R12: reserved write mode enables nothing
    writeMode = 2'd3;
    op(0, 1, 8'hFF, 32'h0, "R12 mode 3 blocked");

    // R13: read and write in the same cycle
    writeMode = 2'd1; readMode = 1'b0; readSel = 2'd1;
    op(1, 0, 8'h00, 32'h1122_3344, "R13 prime latch");
    op(1, 1, 8'h00, 32'h5566_7788, "R13 same-cycle");
    op(0, 1, 8'h00, 32'h0, "R13 next write sees new latch");
    writeMode = 2'd0; aluFn = 2'd3;
    op(1, 1, 8'hC3, 32'h99AA_BBCC, "R13 same-cycle xor");
    aluFn = 2'd0;

    repeat (4) @(negedge clk);
    if (sbQ.size() != 0) check(1'b0, "R9 items left unchecked", sbQ.size(), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule